// File: doc/BRIEF.md
# Double-Buffered UART Transmitter

This block serialises bytes onto an asynchronous transmit line. A one-byte holding register sits in front of the frame shifter, so a new byte can be queued while the current frame is still going out. When the shifter is idle, a queued byte moves into it on the next clock. When a byte is queued behind a frame in progress, the next frame starts two clocks after the current one ends.

Each frame is a low start bit, eight data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. Every bit lasts sixteen baud ticks, and the ticks come from an external rate generator. The block runs only while both the power enable and the transmit enable are high. Dropping either one stops any frame in progress, empties the holding register and returns the line to idle. An output option inverts the serial line, and the inversion acts on the line alone.

Top module: `uart_dbtx`

## Requirements
- R1: After reset, and whenever the shifter is idle, `txd` rests at the idle level: 1 with `inv_out`=0, 0 with `inv_out`=1. `buf_full`, `shift_busy` and `done_pulse` reset to 0.
- R2: A frame starts with a start bit (line level 0) and then sends the 8 data bits least significant bit first. With `baud_tick` high on every clock, each bit lasts exactly 16 clocks.
- R3: `par_mode` encoding: 2'b00 sends no parity bit, 2'b01 sends a parity bit of 0, 2'b10 sends even parity (the XOR of the data bits), and 2'b11 sends odd parity (the inverse of that XOR). The parity bit follows the last data bit.
- R4: `two_stop`=0 sends one stop bit at line level 1. `two_stop`=1 sends two.
- R5: A write accepted while `buf_full`=0 shows as `buf_full`=1 one clock later. If the shifter is idle, `buf_full` falls again on the following clock and `shift_busy` rises.
- R6: A byte written while a frame is shifting stays in the holding register. `buf_full` stays 1 until that frame's last stop bit has ended and the inter-frame gap has passed.
- R7: With a byte queued, the next start bit begins exactly 2 clocks after the final stop bit ends. Start-to-start spacing is 16*(bits in frame)+2 clocks.
- R8: `shift_busy` is 1 from the load of a frame until its final stop bit ends. It stays 1 across the gap when another byte is queued, and it falls together with the completion pulse of the last frame.
- R9: `done_pulse` is high for exactly one clock per frame. It appears in the first cycle after the final stop bit.
- R10: With `inv_out`=1, every level on `txd` is the complement of the non-inverted frame. Frame content and timing do not change.
- R11: Writes are ignored unless `pwr_en` and `tx_en` are both 1. Clearing either one aborts the frame: within 2 clocks `txd` is idle and `buf_full` and `shift_busy` are 0, and no completion pulse follows.
- R12: Bit timing advances only on `baud_tick`. With one tick every 3 clocks, a bit lasts 46 to 48 clocks, depending on where the frame starts relative to the tick phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_en | input | 1 | Master power enable |
| tx_en | input | 1 | Transmit enable (only active with `pwr_en`) |
| wr_stb | input | 1 | Byte write strobe, one clock |
| wr_data | input | 8 | Byte to transmit |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| par_mode | input | 2 | Parity select (see R3) |
| two_stop | input | 1 | 1 selects two stop bits |
| inv_out | input | 1 | 1 inverts the transmit line |
| txd | output | 1 | Serial transmit line (registered) |
| buf_full | output | 1 | Holding register occupied |
| shift_busy | output | 1 | Frame being shifted out |
| done_pulse | output | 1 | One-clock pulse at the end of each frame |

## Verification
Each result has a fixed latency after its stimulus:
- `buf_full` is due one clock after a write strobe.
- The hand-off into an idle shifter is due one clock after that, which is also when `shift_busy` rises.
- `txd` trails the shifter by one register, so the start bit appears three clocks after the strobe.
- `done_pulse` and the fall of `shift_busy` come in the clock after the last stop-bit tick.

Inputs are driven and outputs sampled on the falling edge. The bench models a receiver. It finds the first start-bit sample, then takes every later bit at its centre, 8 + 16k samples after that first sample. From the same first sample it computes the exact cycles of the busy and completion checks and the start-to-start spacing, so each check falls in the cycle where the result is due.

// File: rtl/uart_dbtx_pkg.sv
// Package: shared types for the double-buffered transmitter.
// Assumes par_mode input bits map directly onto par_mode_e.
package uart_dbtx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_ODD  = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        SH_IDLE   = 3'd0,
        SH_START  = 3'd1,
        SH_DATA   = 3'd2,
        SH_PARITY = 3'd3,
        SH_STOP   = 3'd4,
        SH_GAP    = 3'd5
    } shift_state_e;

endpackage

// File: rtl/uart_dbtx_hold.sv
// Module: one-entry holding register in front of the shifter.
// Accepts a write only while empty and active; empties when the shifter
// takes the byte or when the block is disabled. Assumes take only when full.
module uart_dbtx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    // Occupancy flag and stored byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (!act) begin
            full <= 1'b0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_stb && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end

endmodule

// File: rtl/uart_dbtx_shift.sv
// Module: frame shifter. Builds start, data (LSB first), optional parity
// and stop bits, each OVERSAMPLE ticks long; inserts GAP_CLKS clocks
// between back-to-back frames. Assumes GAP_CLKS >= 1, OVERSAMPLE >= 2.
module uart_dbtx_shift
    import uart_dbtx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16,
    parameter int GAP_CLKS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act,
    input  logic              tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  par_mode_e         par_mode,
    input  logic              two_stop,
    output logic              take,
    output logic              line,
    output logic              busy,
    output logic              done
);

    localparam int TW = $clog2(OVERSAMPLE);
    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int GW = $clog2(GAP_CLKS + 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(OVERSAMPLE - 1);
    localparam logic [BW-1:0] BIT_LAST  = BW'(DATA_W - 1);
    localparam logic [GW-1:0] GAP_LAST  = GW'(GAP_CLKS - 1);

    shift_state_e      state;
    logic [TW-1:0]     tick_cnt;
    logic [BW-1:0]     bit_idx;
    logic [GW-1:0]     gap_cnt;
    logic              stop_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              bit_end;
    logic              par_calc;

    // Parity bit for the byte about to be loaded.
    always_comb begin
        unique case (par_mode)
            PAR_EVEN: par_calc = ^hold_data;
            PAR_ODD:  par_calc = ~^hold_data;
            default:  par_calc = 1'b0;
        endcase
    end

    // Last tick of the current bit period.
    assign bit_end = tick && (tick_cnt == TICK_LAST);

    // Shifter takes the held byte when idle or when the gap has elapsed.
    assign take = act && hold_full &&
                  ((state == SH_IDLE) || ((state == SH_GAP) && (gap_cnt == GAP_LAST)));

    // Frame sequencer: state, counters, data shift register, completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !act) begin
            state    <= SH_IDLE;
            tick_cnt <= '0;
            bit_idx  <= '0;
            gap_cnt  <= '0;
            stop_idx <= 1'b0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick && (state != SH_IDLE) && (state != SH_GAP)) begin
                tick_cnt <= bit_end ? '0 : tick_cnt + 1'b1;
            end
            unique case (state)
                SH_IDLE: begin
                    if (take) begin
                        state    <= SH_START;
                        shreg    <= hold_data;
                        par_bit  <= par_calc;
                        tick_cnt <= '0;
                    end
                end
                SH_START: begin
                    if (bit_end) begin
                        state   <= SH_DATA;
                        bit_idx <= '0;
                    end
                end
                SH_DATA: begin
                    if (bit_end) begin
                        shreg <= shreg >> 1;
                        if (bit_idx == BIT_LAST) begin
                            state    <= (par_mode == PAR_NONE) ? SH_STOP : SH_PARITY;
                            stop_idx <= 1'b0;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                SH_PARITY: begin
                    if (bit_end) begin
                        state    <= SH_STOP;
                        stop_idx <= 1'b0;
                    end
                end
                SH_STOP: begin
                    if (bit_end) begin
                        if (two_stop && !stop_idx) begin
                            stop_idx <= 1'b1;
                        end else begin
                            done    <= 1'b1;
                            gap_cnt <= '0;
                            state   <= hold_full ? SH_GAP : SH_IDLE;
                        end
                    end
                end
                SH_GAP: begin
                    if (gap_cnt == GAP_LAST) begin
                        state    <= SH_START;
                        shreg    <= hold_data;
                        par_bit  <= par_calc;
                        tick_cnt <= '0;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    // Uninverted line level for the current state.
    always_comb begin
        unique case (state)
            SH_START:  line = 1'b0;
            SH_DATA:   line = shreg[0];
            SH_PARITY: line = par_bit;
            default:   line = 1'b1;
        endcase
    end

    assign busy = (state != SH_IDLE);

endmodule

// File: rtl/uart_dbtx_out.sv
// Module: output stage. Registers the line level with optional inversion
// so txd is glitch-free. Resets to the non-inverted idle level.
module uart_dbtx_out (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic inv,
    output logic txd
);

    // Registered, optionally inverted serial output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd <= 1'b1;
        end else begin
            txd <= line ^ inv;
        end
    end

endmodule

// File: rtl/uart_dbtx.sv
// Module: top of the double-buffered transmitter. Gates everything on
// pwr_en AND tx_en, then chains holding register, shifter and output stage.
// Assumes configuration inputs change only while tx_en is low.
module uart_dbtx
    import uart_dbtx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16,
    parameter int GAP_CLKS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_en,
    input  logic              tx_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              baud_tick,
    input  logic [1:0]        par_mode,
    input  logic              two_stop,
    input  logic              inv_out,
    output logic              txd,
    output logic              buf_full,
    output logic              shift_busy,
    output logic              done_pulse
);

    logic              act;
    logic              take;
    logic              line;
    logic [DATA_W-1:0] hold_data;

    // Two-level enable: transmit enable counts only under power enable.
    assign act = pwr_en && tx_en;

    uart_dbtx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .take    (take),
        .full    (buf_full),
        .data    (hold_data)
    );

    uart_dbtx_shift #(
        .DATA_W     (DATA_W),
        .OVERSAMPLE (OVERSAMPLE),
        .GAP_CLKS   (GAP_CLKS)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .tick      (baud_tick),
        .hold_full (buf_full),
        .hold_data (hold_data),
        .par_mode  (par_mode_e'(par_mode)),
        .two_stop  (two_stop),
        .take      (take),
        .line      (line),
        .busy      (shift_busy),
        .done      (done_pulse)
    );

    uart_dbtx_out u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .line  (line),
        .inv   (inv_out),
        .txd   (txd)
    );

endmodule

// File: rtl/uart_dbtx_chk.sv
// Module: protocol checker for uart_dbtx, attached by bind below.
// Observes top-level ports only.
module uart_dbtx_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_en,
    input logic tx_en,
    input logic wr_stb,
    input logic inv_out,
    input logic txd,
    input logic buf_full,
    input logic shift_busy,
    input logic done_pulse
);

    logic act;
    assign act = pwr_en && tx_en;

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_busy |=> (txd == !$past(inv_out)));                       // R1
    AST_FULL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (act && wr_stb && !buf_full) |=> buf_full);                      // R5
    AST_FULL_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (act && buf_full && !shift_busy) |=> !buf_full);                 // R5
    AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(shift_busy) && $past(act)) |-> done_pulse);               // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);                                     // R9
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> (!buf_full && !shift_busy && !done_pulse));             // R11

endmodule

bind uart_dbtx uart_dbtx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_en     (pwr_en),
    .tx_en      (tx_en),
    .wr_stb     (wr_stb),
    .inv_out    (inv_out),
    .txd        (txd),
    .buf_full   (buf_full),
    .shift_busy (shift_busy),
    .done_pulse (done_pulse)
);

// File: tb/uart_dbtx_bench.sv
// Bench: vector table of single frames, then directed tests for reset,
// back-to-back gap, enable gating and slow tick rate.
module uart_dbtx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_en = 1'b0;
    logic       tx_en = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic       baud_tick = 1'b0;
    logic [1:0] par_mode = 2'b00;
    logic       two_stop = 1'b0;
    logic       inv_out = 1'b0;
    logic       txd, buf_full, shift_busy, done_pulse;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tick_div = 1;
    int done_cnt = 0;

    // {data, par_mode, two_stop, inv_out}
    localparam logic [11:0] VECS [0:5] = '{
        {8'hA5, 2'b00, 1'b0, 1'b0},
        {8'h3C, 2'b10, 1'b0, 1'b0},
        {8'h3C, 2'b11, 1'b1, 1'b0},
        {8'h07, 2'b10, 1'b0, 1'b0},
        {8'h80, 2'b01, 1'b1, 1'b1},
        {8'h5A, 2'b11, 1'b0, 1'b1}
    };

    uart_dbtx u_uart_dbtx (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .tx_en(tx_en),
        .wr_stb(wr_stb), .wr_data(wr_data), .baud_tick(baud_tick),
        .par_mode(par_mode), .two_stop(two_stop), .inv_out(inv_out),
        .txd(txd), .buf_full(buf_full), .shift_busy(shift_busy),
        .done_pulse(done_pulse)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (done_pulse) done_cnt <= done_cnt + 1;
    end

    always @(negedge clk) baud_tick <= ((cyc % tick_div) == 0);

    always @(negedge clk) begin
        if (cyc == 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: act=%0d exp=%0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] pm, input logic ts, input logic inv);
        @(negedge clk);
        tx_en = 1'b0;
        par_mode = pm; two_stop = ts; inv_out = inv;
        @(negedge clk);
        tx_en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic exp_par(input logic [7:0] d, input logic [1:0] pm);
        case (pm)
            2'b10:   return ^d;
            2'b11:   return ~^d;
            default: return 1'b0;
        endcase
    endfunction

    // Receiver model: locate start, sample each bit at its centre.
    task automatic rx_frame(input logic [7:0] d, input logic [1:0] pm, input logic ts,
                            input logic inv, input bit more, output int t0);
        int guard = 0;
        int nbits;
        while (txd !== inv && guard < 400) begin
            @(negedge clk);
            guard++;
        end
        chk(txd === inv, "R2 start bit found", txd, inv);
        t0 = cyc;
        repeat (8) @(negedge clk);
        chk(txd === inv, "R2 start level", txd, inv);
        for (int i = 0; i < 8; i++) begin
            repeat (16) @(negedge clk);
            chk(txd === (d[i] ^ inv), "R2 data bit LSB first", txd, d[i] ^ inv);
        end
        if (pm != 2'b00) begin
            repeat (16) @(negedge clk);
            chk(txd === (exp_par(d, pm) ^ inv), "R3 parity bit", txd, exp_par(d, pm) ^ inv);
        end
        for (int s = 0; s < (ts ? 2 : 1); s++) begin
            repeat (16) @(negedge clk);
            chk(txd === !inv, "R4 stop bit", txd, !inv);
        end
        nbits = 9 + ((pm != 2'b00) ? 1 : 0) + (ts ? 2 : 1);
        repeat (6) @(negedge clk);
        chk(shift_busy === 1'b1, "R8 busy through last stop", shift_busy, 1);
        chk(done_pulse === 1'b0, "R9 no early done", done_pulse, 0);
        @(negedge clk);
        chk(cyc - t0 == 16 * nbits - 1, "R2 frame length", cyc - t0, 16 * nbits - 1);
        chk(done_pulse === 1'b1, "R9 done at frame end", done_pulse, 1);
        chk(shift_busy === more, "R8 busy after frame", shift_busy, more);
    endtask

    initial begin
        int ta, tb, d0, lowc;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(txd === 1'b1, "R1 reset txd", txd, 1);
        chk(buf_full === 1'b0, "R1 reset buf_full", buf_full, 0);
        chk(shift_busy === 1'b0, "R1 reset busy", shift_busy, 0);
        chk(done_pulse === 1'b0, "R1 reset done", done_pulse, 0);
        rst_n = 1'b1;
        @(negedge clk);
        pwr_en = 1'b1;

        // Vector table of single frames
        for (int v = 0; v < 6; v++) begin
            logic [7:0] d;
            logic [1:0] pm;
            logic ts, inv;
            {d, pm, ts, inv} = VECS[v];
            set_cfg(pm, ts, inv);
            chk(txd === !inv, "R1 R10 idle level", txd, !inv);
            write_byte(d);
            chk(buf_full === 1'b1, "R5 full after write", buf_full, 1);
            @(negedge clk);
            chk(buf_full === 1'b0, "R5 handoff clears full", buf_full, 0);
            chk(shift_busy === 1'b1, "R5 busy on load", shift_busy, 1);
            rx_frame(d, pm, ts, inv, 1'b0, ta);
            repeat (3) @(negedge clk);
            chk(txd === !inv, "R1 idle after frame", txd, !inv);
        end

        // R6 R7: back-to-back frames, one and two stop bits
        for (int s = 0; s < 2; s++) begin
            set_cfg(2'b00, s[0], 1'b0);
            write_byte(8'hC3);
            fork
                rx_frame(8'hC3, 2'b00, s[0], 1'b0, 1'b1, ta);
                begin
                    repeat (5) @(negedge clk);
                    write_byte(8'h96);
                    chk(buf_full === 1'b1, "R6 queued byte held", buf_full, 1);
                    repeat (60) @(negedge clk);
                    chk(buf_full === 1'b1, "R6 full during frame", buf_full, 1);
                end
            join
            @(negedge clk);
            chk(buf_full === 1'b1, "R6 full through gap", buf_full, 1);
            @(negedge clk);
            chk(buf_full === 1'b0, "R6 full clears at gap end", buf_full, 0);
            rx_frame(8'h96, 2'b00, s[0], 1'b0, 1'b0, tb);
            chk(tb - ta == 16 * (s == 0 ? 10 : 11) + 2, "R7 start-to-start spacing",
                tb - ta, 16 * (s == 0 ? 10 : 11) + 2);
        end

        // R11: abort mid-frame and writes while disabled
        set_cfg(2'b10, 1'b0, 1'b0);
        write_byte(8'h00);
        repeat (40) @(negedge clk);
        d0 = done_cnt;
        tx_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(txd === 1'b1, "R11 abort idle line", txd, 1);
        chk(shift_busy === 1'b0, "R11 abort clears busy", shift_busy, 0);
        chk(buf_full === 1'b0, "R11 abort clears full", buf_full, 0);
        write_byte(8'h55);
        repeat (2) @(negedge clk);
        chk(buf_full === 1'b0, "R11 write ignored tx_en=0", buf_full, 0);
        pwr_en = 1'b0; tx_en = 1'b1;
        write_byte(8'h55);
        repeat (2) @(negedge clk);
        chk(buf_full === 1'b0, "R11 write ignored pwr_en=0", buf_full, 0);
        chk(txd === 1'b1, "R11 line idle while off", txd, 1);
        repeat (200) @(negedge clk);
        chk(done_cnt == d0, "R11 no done after abort", done_cnt, d0);
        pwr_en = 1'b1;
        repeat (2) @(negedge clk);

        // R12: one tick every 3 clocks
        set_cfg(2'b00, 1'b0, 1'b0);
        tick_div = 3;
        write_byte(8'hFF);
        lowc = 0;
        while (txd !== 1'b0 && lowc < 50) begin
            @(negedge clk);
            lowc++;
        end
        lowc = 0;
        while (txd === 1'b0 && lowc < 200) begin
            @(negedge clk);
            lowc++;
        end
        chk(lowc >= 46 && lowc <= 48, "R12 bit length at tick/3", lowc, 48);
        lowc = 0;
        while (shift_busy === 1'b1 && lowc < 1000) begin
            @(negedge clk);
            lowc++;
        end
        chk(shift_busy === 1'b0, "R12 slow frame completes", shift_busy, 0);
        tick_div = 1;

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule